// File: doc/BRIEF.md
# Pin Controller with Per-Pin Trigger Detection

This block is a memory-mapped general-purpose pin controller for up to sixteen pins (twelve by default). Each pin has a direction bit, an output latch bit and a synchronised input read-back. Each pin also has an event detector. Software picks, per pin, whether a rising edge, a falling edge, either edge, a high level or a low level raises the pin's event.

Events land in a sticky status vector when the pin's enable bit is set. They stay there until software acknowledges them with a write-one-to-clear. A mask, driven through separate set and clear strobes, gates the status into a single combined interrupt line. A software reset register returns the whole register set to its power-up state when it is written with one and then zero.

The host port is a plain 32-bit register interface with word addresses. Writes are single-cycle strobes. Reads are combinational from a separate read address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Word addresses are: 0 enable, 1 status, 2 masked status view, 3 acknowledge, 4 mask set (reads the mask), 5 mask clear, 6 output latch, 7 input levels, 8 direction, 9 trigger modes of pins 0-7, 10 trigger modes of pins 8-15, 14 pin select, 15 software reset (bit 0). Addresses 3, 5, 11, 12 and 13 read zero. The select register drives `pin_sel`.
- R2: `pin_oe` follows the direction register (1 = output) and `pin_out` follows the output latch.
- R3: Address 7 returns `pin_in` through a two-stage synchroniser. A change applied before clock edge k is visible after edge k+1 and not after edge k.
- R4: A write to address 4 sets every mask bit that is written as one. A write to address 5 clears every mask bit written as one. Zero bits leave the mask as it was.
- R5: Writing a one to a bit of address 3 clears that pin's status bit, unless the pin raises a new enabled event in the same cycle.
- R6: A status bit sets only when its pin raises an event while its enable bit is 1. Once set, it stays set until acknowledged.
- R7: Pin p's 3-bit trigger code sits at bits [4·(p mod 8)+2 : 4·(p mod 8)] of address 9 (p < 8) or address 10 (p ≥ 8). The codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 either edge. Codes 5 to 7 raise no event.
- R8: In the level modes, the event is raised on every cycle that the level holds, so acknowledging it while the level persists leaves the status set.
- R9: `irq` is high exactly when some status bit is set whose mask bit is 0. Address 2 reads status AND NOT mask.
- R10: Register bits at or above the pin count read zero and ignore writes.
- R11: Writing 1 to address 15 holds every other register in its reset state until 0 is written there. Address 15 bit 0 reads back the written value.
- R12: After reset the mask is all ones (pin bits). Enable, status, direction, output latch, select and trigger modes are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pin_in | input | N_PINS | Pin levels from the pads |
| pin_out | output | N_PINS | Output latch towards the pads |
| pin_oe | output | N_PINS | Output enable per pin |
| pin_sel | output | N_PINS | Plain pin select register value |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
A corrupted trigger code, a wrong slot position or a mis-aligned synchroniser shows up as a status bit that is wrong within four cycles of a pin transition. The bench sweeps every pin against every defined trigger code, and for each it checks the status after a rise, after acknowledge, after a fall and after acknowledge again. A mask or status fault appears on `irq` and on the masked view in the same cycle as the register changes. A stuck or mis-reset register shows up on the first read after reset or after a software reset.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int SLOT_W   = 4;
    localparam int CODE_W   = 3;
    localparam int SLOTS    = DATA_W / SLOT_W;
    localparam int MAX_PINS = 2 * SLOTS;

    typedef enum logic [CODE_W-1:0] {
        TRIG_FALL   = 3'd0,
        TRIG_RISE   = 3'd1,
        TRIG_LVL_LO = 3'd2,
        TRIG_LVL_HI = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        A_EN      = 4'd0,
        A_STAT    = 4'd1,
        A_VIEW    = 4'd2,
        A_ACK     = 4'd3,
        A_MSET    = 4'd4,
        A_MCLR    = 4'd5,
        A_OUT     = 4'd6,
        A_IN      = 4'd7,
        A_DIR     = 4'd8,
        A_MODE_LO = 4'd9,
        A_MODE_HI = 4'd10,
        A_SEL     = 4'd14,
        A_SRST    = 4'd15
    } addr_e;

    // Event decision for one pin from its trigger code and two samples.
    function automatic logic trig_hit(logic [CODE_W-1:0] code, logic now, logic prev);
        logic r;
        case (code)
            TRIG_FALL:   r = !now && prev;
            TRIG_RISE:   r = now && !prev;
            TRIG_LVL_LO: r = !now;
            TRIG_LVL_HI: r = now;
            TRIG_BOTH:   r = now ^ prev;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int N_PINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] lvl,
    output logic [N_PINS-1:0] lvl_d
);
    logic [N_PINS-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            lvl    <= '0;
            lvl_d  <= '0;
        end else begin
            stage1 <= pin_in;
            lvl    <= stage1;
            lvl_d  <= lvl;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 12
) (
    input  logic [N_PINS-1:0]             lvl,
    input  logic [N_PINS-1:0]             lvl_d,
    input  logic [N_PINS-1:0][CODE_W-1:0] codes,
    output logic [N_PINS-1:0]             hit
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        assign hit[p] = trig_hit(codes[p], lvl[p], lvl_d[p]);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    input  logic [N_PINS-1:0]             lvl,
    input  logic [N_PINS-1:0]             hit,
    output logic [N_PINS-1:0][CODE_W-1:0] codes,
    output logic [N_PINS-1:0]             dir_q,
    output logic [N_PINS-1:0]             out_q,
    output logic [N_PINS-1:0]             sel_q,
    output logic                          irq
);
    logic              srst_q;
    logic [N_PINS-1:0] en_q, mask_q, stat_q;
    logic [N_PINS-1:0] wbits, ack_v, mset_v, mclr_v, fire, view;
    logic              hold;

    assign wbits  = wr_data[N_PINS-1:0];
    assign hold   = rst || srst_q;
    assign ack_v  = (wr_en && wr_addr == A_ACK)  ? wbits : '0;
    assign mset_v = (wr_en && wr_addr == A_MSET) ? wbits : '0;
    assign mclr_v = (wr_en && wr_addr == A_MCLR) ? wbits : '0;
    assign fire   = hit & en_q;
    assign view   = stat_q & ~mask_q;
    assign irq    = |view;

    always_ff @(posedge clk) begin
        if (rst) srst_q <= 1'b0;
        else if (wr_en && wr_addr == A_SRST) srst_q <= wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (hold) begin
            en_q   <= '0;
            mask_q <= '1;
            stat_q <= '0;
            dir_q  <= '0;
            out_q  <= '0;
            sel_q  <= '0;
        end else begin
            if (wr_en && wr_addr == A_EN)  en_q  <= wbits;
            if (wr_en && wr_addr == A_DIR) dir_q <= wbits;
            if (wr_en && wr_addr == A_OUT) out_q <= wbits;
            if (wr_en && wr_addr == A_SEL) sel_q <= wbits;
            mask_q <= (mask_q | mset_v) & ~mclr_v;
            stat_q <= (stat_q & ~ack_v) | fire;
        end
    end

    for (genvar p = 0; p < N_PINS; p++) begin : g_code
        localparam addr_e MY_REG = (p < SLOTS) ? A_MODE_LO : A_MODE_HI;
        localparam int    MY_OFF = (p % SLOTS) * SLOT_W;
        always_ff @(posedge clk) begin
            if (hold) codes[p] <= '0;
            else if (wr_en && wr_addr == MY_REG) codes[p] <= wr_data[MY_OFF +: CODE_W];
        end
    end

    logic [DATA_W-1:0] lo_word, hi_word;
    always_comb begin
        lo_word = '0;
        hi_word = '0;
        for (int p = 0; p < N_PINS; p++) begin
            if (p / SLOTS == 0) lo_word[(p % SLOTS) * SLOT_W +: CODE_W] = codes[p];
            else                hi_word[(p % SLOTS) * SLOT_W +: CODE_W] = codes[p];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_EN:      rd_data[N_PINS-1:0] = en_q;
            A_STAT:    rd_data[N_PINS-1:0] = stat_q;
            A_VIEW:    rd_data[N_PINS-1:0] = view;
            A_MSET:    rd_data[N_PINS-1:0] = mask_q;
            A_OUT:     rd_data[N_PINS-1:0] = out_q;
            A_IN:      rd_data[N_PINS-1:0] = lvl;
            A_DIR:     rd_data[N_PINS-1:0] = dir_q;
            A_SEL:     rd_data[N_PINS-1:0] = sel_q;
            A_MODE_LO: rd_data = lo_word;
            A_MODE_HI: rd_data = hi_word;
            A_SRST:    rd_data[0] = srst_q;
            default:   rd_data = '0;
        endcase
    end

    p_mask_set_r4: assert property (@(posedge clk) disable iff (rst)
        (!srst_q && |mset_v) |=> ((mask_q & $past(mset_v)) == $past(mset_v)));

    p_mask_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (!srst_q && |mclr_v) |=> ((mask_q & $past(mclr_v)) == '0));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (|ack_v) |=> ((stat_q & $past(ack_v & ~fire)) == '0));

    p_set_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

    p_event_latched_r8: assert property (@(posedge clk) disable iff (rst)
        (!srst_q && |fire) |=> ((stat_q & $past(fire)) == $past(fire)));

    p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q != '0));

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_addr inside {A_EN, A_STAT, A_VIEW, A_MSET, A_OUT, A_IN, A_DIR, A_SEL})
        |-> (rd_data[DATA_W-1:N_PINS] == '0));

    p_soft_reset_r11: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (mask_q == '1 && en_q == '0 && stat_q == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_sel,
    output logic              irq
);
    logic [N_PINS-1:0]             lvl, lvl_d, hit;
    logic [N_PINS-1:0][CODE_W-1:0] codes;

    gpio_irq_sync #(.N_PINS(N_PINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .lvl(lvl), .lvl_d(lvl_d)
    );

    gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
        .lvl(lvl), .lvl_d(lvl_d), .codes(codes), .hit(hit)
    );

    gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .lvl(lvl), .hit(hit), .codes(codes),
        .dir_q(pin_oe), .out_q(pin_out), .sel_q(pin_sel), .irq(irq)
    );

    initial begin
        assert (N_PINS >= 1 && N_PINS <= MAX_PINS);
    end
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/100ps
module gpio_irq_ctrl_tb;
    localparam int N = 12;
    localparam logic [31:0] ALL = (32'd1 << N) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe, pin_sel;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.N_PINS(N)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_sel(pin_sel), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] slot_word(input int pin, input int code, input int reg_sel);
        logic [31:0] w = '0;
        for (int s = 0; s < 8; s++) begin
            int q = reg_sel * 8 + s;
            w[s*4 +: 3] = (q == pin) ? code[2:0] : 3'd5;
        end
        return w;
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst = 1'b0;

        // R12 reset state
        rd(4'd4, d);  chk("R12 mask", d, ALL);
        rd(4'd0, d);  chk("R12 enable", d, 0);
        rd(4'd1, d);  chk("R12 status", d, 0);
        rd(4'd8, d);  chk("R12 dir", d, 0);
        rd(4'd6, d);  chk("R12 out", d, 0);
        rd(4'd9, d);  chk("R12 modes lo", d, 0);
        rd(4'd10, d); chk("R12 modes hi", d, 0);
        chk("R12 irq", {31'd0, irq}, 0);

        // R1 reserved / write-only reads, select register
        for (int a = 11; a <= 13; a++) begin
            rd(a[3:0], d); chk("R1 reserved", d, 0);
        end
        wr(4'd14, 32'h123);
        chk("R1 select pin", {20'd0, pin_sel}, 32'h123);
        rd(4'd14, d); chk("R1 select read", d, 32'h123);

        // R10 upper bits
        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd6, d); chk("R10 out upper", d, ALL);

        // R2 direction and output latch
        wr(4'd8, 32'hA5A);
        wr(4'd6, 32'h3C3);
        chk("R2 oe", {20'd0, pin_oe}, 32'hA5A);
        chk("R2 out", {20'd0, pin_out}, 32'h3C3);

        // R3 synchroniser latency
        @(negedge clk); pin_in = 12'h5A5;
        rd(4'd7, d); chk("R3 one edge", d, 0);
        rd(4'd7, d); chk("R3 two edges", d, 32'h5A5);
        pin_in = '0;
        idle(4);

        // R4 mask set / clear
        wr(4'd5, 32'h00F); rd(4'd4, d); chk("R4 clear", d, 32'hFF0);
        wr(4'd4, 32'h001); rd(4'd4, d); chk("R4 set", d, 32'hFF1);
        wr(4'd5, 32'h000); rd(4'd4, d); chk("R4 zero clear", d, 32'hFF1);
        wr(4'd4, 32'h000); rd(4'd4, d); chk("R4 zero set", d, 32'hFF1);

        // R11 software reset
        wr(4'd0, ALL);
        wr(4'd15, 32'h1);
        rd(4'd15, d); chk("R11 readback", d, 1);
        wr(4'd0, 32'h00F);
        wr(4'd15, 32'h0);
        rd(4'd0, d); chk("R11 enable", d, 0);
        rd(4'd4, d); chk("R11 mask", d, ALL);
        rd(4'd14, d); chk("R11 select", d, 0);

        // R7 R8 R5 R9: sweep every pin against every defined code
        for (int p = 0; p < N; p++) begin
            for (int m = 0; m < 5; m++) begin
                logic [31:0] b;
                b = 32'd1 << p;
                pin_in = '0;
                wr(4'd0, ALL);
                wr(4'd5, ALL);
                wr(4'd9, slot_word(p, m, 0));
                wr(4'd10, slot_word(p, m, 1));
                idle(4);
                wr(4'd3, ALL);
                rd(4'd1, d); chk("R8 low start", d, (m == 2) ? b : 0);
                @(negedge clk); pin_in[p] = 1'b1;
                idle(4);
                rd(4'd1, d); chk("R7 after rise", d, (m != 0) ? b : 0);
                rd(4'd2, d); chk("R9 view rise", d, (m != 0) ? b : 0);
                chk("R9 irq rise", {31'd0, irq}, (m != 0) ? 1 : 0);
                wr(4'd3, b);
                rd(4'd1, d); chk("R5 ack high", d, (m == 3) ? b : 0);
                @(negedge clk); pin_in[p] = 1'b0;
                idle(4);
                rd(4'd1, d); chk("R7 after fall", d, (m != 1) ? b : 0);
                wr(4'd3, b);
                rd(4'd1, d); chk("R8 ack low", d, (m == 2) ? b : 0);
            end
        end

        // R7 undefined code on pin 3
        wr(4'd9, 32'h0000_6000);
        wr(4'd10, 32'h0);
        wr(4'd3, ALL);
        @(negedge clk); pin_in[3] = 1'b1; idle(4);
        @(negedge clk); pin_in[3] = 1'b0; idle(4);
        rd(4'd1, d); chk("R7 code 6 silent", d, 0);

        // R6 enable gating, pin 0 rising
        wr(4'd9, 32'h0000_0001);
        wr(4'd0, 32'h0);
        @(negedge clk); pin_in[0] = 1'b1; idle(4);
        rd(4'd1, d); chk("R6 disabled", d, 0);
        wr(4'd0, ALL);
        idle(3);
        rd(4'd1, d); chk("R6 late enable", d, 0);
        @(negedge clk); pin_in[0] = 1'b0; idle(2);
        @(negedge clk); pin_in[0] = 1'b1; idle(4);
        rd(4'd1, d); chk("R6 set", d, 1);
        idle(5);
        rd(4'd1, d); chk("R6 sticky", d, 1);

        // R9 masking
        wr(4'd4, 32'h1);
        chk("R9 masked irq", {31'd0, irq}, 0);
        rd(4'd2, d); chk("R9 masked view", d, 0);
        wr(4'd5, 32'h1);
        chk("R9 unmasked irq", {31'd0, irq}, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule